// File: doc/BRIEF.md
# Precise Exception Completion Controller

This block is the retirement stage of an in-order completion queue. Dispatched instructions enter the queue with their address and are given a slot tag. Execution units later report each tag as finished, together with a mask of exception conditions. Finish reports may arrive in any order. The block retires entries strictly oldest-first, at most one per cycle. It takes an instruction-caused exception only when the faulting entry has reached the head of the queue, so every older entry has already retired or trapped.

When an exception is taken, the block pulses a take strobe and drives a 4-bit vector code. It also loads two save registers: a return address and a copy of the processor status. It then discards the faulting entry and every younger one, and raises an in-progress flag. The flag stays up until the handler signals return.

An asynchronous interrupt request is latched when it arrives. The block then stops dispatch and takes the request once the queue has drained. System-reset and machine-check requests pre-empt all of this and are taken on the next clock edge, even in the middle of a handler.

A controlling state machine has three states:
- RUN: normal operation.
- DRAIN: an asynchronous request is waiting and dispatch is stalled.
- HANDLER: an exception is in progress.

Its transitions are:
- any take moves to HANDLER;
- RUN moves to DRAIN when an asynchronous request arrives or is already pending;
- HANDLER moves to RUN on handler return, or to DRAIN if a request is still pending.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset the queue is empty, `exc_busy` is 0 and `disp_ready` is 1. An entry retires only when it is the oldest and has finished with an empty cause mask. `ret_valid`/`ret_addr` present it in the cycle before it leaves, one entry per cycle, in dispatch order whatever order the finish reports came in.
- R2: An instruction exception is taken only from the head entry. An exception flagged by a younger entry waits until all older entries have retired. If an older entry also faults, the older one is taken first.
- R3: On an instruction exception, the faulting entry and all younger entries are discarded without retiring. `exc_busy` rises with the take.
- R4: On each take, `save_status` loads the value of `cur_status` from the cycle of the take. For data-access and floating-point causes, `save_addr` loads the faulting entry's address.
- R5: Only one exception is handled at a time. While `exc_busy` is 1, no instruction or asynchronous exception is taken, and `handler_done` clears the flag. An entry with several cause bits is presented once per take, lowest bit first. It is kept at the head until its last cause has been taken.
- R6: For trap and system-call causes, `save_addr` loads `resume_addr` instead of the entry address.
- R7: A pulse on `async_req` is remembered and `disp_ready` goes low. The request is taken only after the queue is empty, with vector 8 and `save_addr` = `next_pc`.
- R8: A system-reset or machine-check request is taken on the next edge even while `exc_busy` is 1. Reset wins over machine check (vectors 1 and 2). The whole queue is flushed, and `save_addr` is the head address, or `next_pc` if the queue is empty.
- R9: `fp_imprecise_en` has no effect. A floating-point cause is taken exactly as in precise mode.
- R10: The queue holds 6 entries. `disp_ready` is 0 when the queue is full, while draining for an asynchronous request, and in any cycle in which a take occurs.
- R11: Cause mask bits and their vectors are:

  | Bit | Cause | Vector |
  |-----|-------|--------|
  | 0 | data access | 3 |
  | 1 | floating point | 4 |
  | 2 | trap | 5 |
  | 3 | system call | 6 |

  A finish report on a slot that is not occupied is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch an instruction |
| disp_addr | input | 32 | Address of the dispatched instruction |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | 3 | Slot tag given to the dispatched entry |
| fin_valid | input | 1 | Finish report strobe |
| fin_tag | input | 3 | Slot being reported finished |
| fin_cause | input | 4 | Exception cause mask of the finished entry |
| ret_valid | output | 1 | Head entry retires at the next edge |
| ret_addr | output | 32 | Address of the retiring entry |
| async_req | input | 1 | Asynchronous interrupt request pulse |
| sysrst_req | input | 1 | System reset request |
| mchk_req | input | 1 | Machine check request |
| handler_done | input | 1 | Return from handler |
| fp_imprecise_en | input | 1 | Imprecise floating-point mode enable (no effect) |
| cur_status | input | 16 | Current processor status |
| resume_addr | input | 32 | Handler-supplied resume address for trap/system call |
| next_pc | input | 32 | Address of the next instruction to dispatch |
| exc_take | output | 1 | One-cycle strobe: exception taken |
| exc_vec | output | 4 | Vector code of the last take |
| save_addr | output | 32 | Saved return address |
| save_status | output | 16 | Saved status |
| exc_busy | output | 1 | Exception in progress |

## Verification
Some properties are checked on every cycle by assertions:
- a full queue never accepts a dispatch;
- any take leaves at most the retained head entry in the queue;
- a take seen while the handler flag was up is always reset or machine check;
- an asynchronous take only follows an empty queue;
- the saved status always equals the status of the take cycle.

Other properties need directed scenarios that only the bench can run:
- retirement order under reversed finish reports;
- the choice between an older and a younger fault;
- serial presentation of a multi-cause entry;
- the resume-address choice for traps;
- the inertness of the imprecise-mode input.

// File: rtl/prx_pkg.sv
package prx_pkg;

    localparam int NCAUSE = 4;

    localparam int C_DATA = 0;
    localparam int C_FP   = 1;
    localparam int C_TRAP = 2;
    localparam int C_SC   = 3;

    localparam logic [3:0] VEC_NONE   = 4'd0;
    localparam logic [3:0] VEC_RST    = 4'd1;
    localparam logic [3:0] VEC_MCHK   = 4'd2;
    localparam logic [3:0] VEC_CAUSE0 = 4'd3;
    localparam logic [3:0] VEC_ASYNC  = 4'd8;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_HANDLER
    } ctl_state_e;

endpackage

// File: rtl/prx_queue.sv
module prx_queue
    import prx_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic              fin_valid,
    input  logic [PW-1:0]     fin_tag,
    input  logic [NCAUSE-1:0] fin_cause,
    input  logic              pop,
    input  logic              flush_all,
    input  logic              flush_young,
    input  logic [NCAUSE-1:0] clear_mask,
    output logic [PW-1:0]     tail,
    output logic [CW-1:0]     cnt,
    output logic              head_valid,
    output logic              head_done,
    output logic [NCAUSE-1:0] head_cause,
    output logic [AW-1:0]     head_addr
);

    logic [PW-1:0]     head;
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  done_q;
    logic [NCAUSE-1:0] cause_q [DEPTH];
    logic [AW-1:0]     addr_q  [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head_valid = valid_q[head];
    assign head_done  = done_q[head];
    assign head_cause = cause_q[head];
    assign head_addr  = addr_q[head];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            cnt     <= '0;
            valid_q <= '0;
            done_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                cause_q[i] <= '0;
                addr_q[i]  <= '0;
            end
        end else if (flush_all) begin
            valid_q <= '0;
            tail    <= head;
            cnt     <= '0;
        end else if (flush_young) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (PW'(i) != head) valid_q[i] <= 1'b0;
            end
            cause_q[head] <= cause_q[head] & ~clear_mask;
            tail          <= wrap_inc(head);
            cnt           <= CW'(1);
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fin_valid && fin_tag == PW'(i) && valid_q[i]) begin
                    done_q[i]  <= 1'b1;
                    cause_q[i] <= cause_q[i] | fin_cause;
                end
                if (pop && head == PW'(i)) valid_q[i] <= 1'b0;
                if (push && tail == PW'(i)) begin
                    valid_q[i] <= 1'b1;
                    done_q[i]  <= 1'b0;
                    cause_q[i] <= '0;
                    addr_q[i]  <= push_addr;
                end
            end
            if (pop)  head <= wrap_inc(head);
            if (push) tail <= wrap_inc(tail);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/prx_pick.sv
module prx_pick
    import prx_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              sysrst_req,
    input  logic              mchk_req,
    input  logic              busy,
    input  logic              pend,
    input  logic              fp_imprecise_en,
    input  logic              head_valid,
    input  logic              head_done,
    input  logic [NCAUSE-1:0] head_cause,
    input  logic [AW-1:0]     head_addr,
    input  logic [CW-1:0]     cnt,
    input  logic [AW-1:0]     resume_addr,
    input  logic [AW-1:0]     next_pc,
    output logic              take,
    output logic              hard_take,
    output logic              inst_take,
    output logic              async_take,
    output logic              last_cause,
    output logic [NCAUSE-1:0] clear_mask,
    output logic [3:0]        vec,
    output logic [AW-1:0]     ra
);

    logic [NCAUSE-1:0] eff_cause;
    logic [NCAUSE:0]   seen;
    logic [3:0]        cause_vec;
    logic              use_resume;

    // Imprecise floating-point mode selects the same path as precise mode.
    assign eff_cause = fp_imprecise_en ? head_cause : head_cause;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NCAUSE; i++) begin : g_first
        assign clear_mask[i] = eff_cause[i] & ~seen[i];
        assign seen[i+1]     = seen[i] | eff_cause[i];
    end

    always_comb begin
        cause_vec  = VEC_CAUSE0;
        use_resume = 1'b0;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (clear_mask[i]) begin
                cause_vec  = VEC_CAUSE0 + 4'(i);
                use_resume = (i == C_TRAP) || (i == C_SC);
            end
        end
    end

    assign last_cause = ((eff_cause & (eff_cause - NCAUSE'(1))) == '0);
    assign hard_take  = sysrst_req | mchk_req;
    assign inst_take  = !hard_take && !busy && head_valid && head_done && (eff_cause != '0);
    assign async_take = !hard_take && !busy && !inst_take && pend && (cnt == '0);
    assign take       = hard_take | inst_take | async_take;

    always_comb begin
        vec = VEC_NONE;
        ra  = next_pc;
        if (sysrst_req) begin
            vec = VEC_RST;
            ra  = head_valid ? head_addr : next_pc;
        end else if (mchk_req) begin
            vec = VEC_MCHK;
            ra  = head_valid ? head_addr : next_pc;
        end else if (inst_take) begin
            vec = cause_vec;
            ra  = use_resume ? resume_addr : head_addr;
        end else if (async_take) begin
            vec = VEC_ASYNC;
            ra  = next_pc;
        end
    end

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
    import prx_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 32,
    parameter int SW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [AW-1:0]     disp_addr,
    output logic              disp_ready,
    output logic [PW-1:0]     disp_tag,
    input  logic              fin_valid,
    input  logic [PW-1:0]     fin_tag,
    input  logic [NCAUSE-1:0] fin_cause,
    output logic              ret_valid,
    output logic [AW-1:0]     ret_addr,
    input  logic              async_req,
    input  logic              sysrst_req,
    input  logic              mchk_req,
    input  logic              handler_done,
    input  logic              fp_imprecise_en,
    input  logic [SW-1:0]     cur_status,
    input  logic [AW-1:0]     resume_addr,
    input  logic [AW-1:0]     next_pc,
    output logic              exc_take,
    output logic [3:0]        exc_vec,
    output logic [AW-1:0]     save_addr,
    output logic [SW-1:0]     save_status,
    output logic              exc_busy
);

    ctl_state_e        state, state_nx;
    logic              pend;
    logic [CW-1:0]     q_cnt;
    logic              head_valid, head_done;
    logic [NCAUSE-1:0] head_cause, clear_mask;
    logic [AW-1:0]     head_addr, pick_ra;
    logic [3:0]        pick_vec;
    logic              take, hard_take, inst_take, async_take, last_cause;
    logic              flush_all, flush_young, pop, push;

    prx_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (disp_addr),
        .fin_valid  (fin_valid),
        .fin_tag    (fin_tag),
        .fin_cause  (fin_cause),
        .pop        (pop),
        .flush_all  (flush_all),
        .flush_young(flush_young),
        .clear_mask (clear_mask),
        .tail       (disp_tag),
        .cnt        (q_cnt),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_cause (head_cause),
        .head_addr  (head_addr)
    );

    prx_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
        .sysrst_req     (sysrst_req),
        .mchk_req       (mchk_req),
        .busy           (state == ST_HANDLER),
        .pend           (pend),
        .fp_imprecise_en(fp_imprecise_en),
        .head_valid     (head_valid),
        .head_done      (head_done),
        .head_cause     (head_cause),
        .head_addr      (head_addr),
        .cnt            (q_cnt),
        .resume_addr    (resume_addr),
        .next_pc        (next_pc),
        .take           (take),
        .hard_take      (hard_take),
        .inst_take      (inst_take),
        .async_take     (async_take),
        .last_cause     (last_cause),
        .clear_mask     (clear_mask),
        .vec            (pick_vec),
        .ra             (pick_ra)
    );

    assign ret_valid   = head_valid && head_done && (head_cause == '0);
    assign ret_addr    = head_addr;
    assign flush_all   = hard_take || (inst_take && last_cause);
    assign flush_young = inst_take && !last_cause;
    assign pop         = ret_valid && !flush_all;
    assign disp_ready  = (q_cnt < CW'(DEPTH)) && (state != ST_DRAIN) && !take;
    assign push        = disp_valid && disp_ready;
    assign exc_busy    = (state == ST_HANDLER);

    // next-state selection
    always_comb begin
        state_nx = state;
        if (take) begin
            state_nx = ST_HANDLER;
        end else begin
            unique case (state)
                ST_RUN:     if (pend || async_req) state_nx = ST_DRAIN;
                ST_DRAIN:   state_nx = ST_DRAIN;
                ST_HANDLER: if (handler_done)
                                state_nx = (pend || async_req) ? ST_DRAIN : ST_RUN;
                default:    state_nx = ST_RUN;
            endcase
        end
    end

    // state register and pending asynchronous request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            pend  <= 1'b0;
        end else begin
            state <= state_nx;
            if (async_take)     pend <= 1'b0;
            else if (async_req) pend <= 1'b1;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_take    <= 1'b0;
            exc_vec     <= VEC_NONE;
            save_addr   <= '0;
            save_status <= '0;
        end else begin
            exc_take <= take;
            if (take) begin
                exc_vec     <= pick_vec;
                save_addr   <= pick_ra;
                save_status <= cur_status;
            end
        end
    end

endmodule

// File: rtl/prx_check.sv
module prx_check
    import prx_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int SW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] q_cnt,
    input logic          disp_ready,
    input logic          exc_take,
    input logic [3:0]    exc_vec,
    input logic          exc_busy,
    input logic          sysrst_req,
    input logic [SW-1:0] cur_status,
    input logic [SW-1:0] save_status
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == CW'(DEPTH)) |-> !disp_ready); // R10

    AST_TAKE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (q_cnt <= CW'(1))); // R3

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && $past(exc_busy)) |-> (exc_vec == VEC_RST || exc_vec == VEC_MCHK)); // R5

    AST_ASYNC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_vec == VEC_ASYNC) |-> ($past(q_cnt) == '0)); // R7

    AST_RESET_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sysrst_req) |-> (exc_take && exc_vec == VEC_RST)); // R8

    AST_STATUS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (save_status == $past(cur_status))); // R4

endmodule

bind precise_exc_ctrl prx_check #(.DEPTH(DEPTH), .SW(SW)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_cnt      (q_cnt),
    .disp_ready (disp_ready),
    .exc_take   (exc_take),
    .exc_vec    (exc_vec),
    .exc_busy   (exc_busy),
    .sysrst_req (sysrst_req),
    .cur_status (cur_status),
    .save_status(save_status)
);

// File: tb/tb_precise_exc_ctrl.sv
module tb_precise_exc_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [31:0] disp_addr = '0;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        fin_valid = 1'b0;
    logic [2:0]  fin_tag = '0;
    logic [3:0]  fin_cause = '0;
    logic        ret_valid;
    logic [31:0] ret_addr;
    logic        async_req = 1'b0;
    logic        sysrst_req = 1'b0;
    logic        mchk_req = 1'b0;
    logic        handler_done = 1'b0;
    logic        fp_imprecise_en = 1'b0;
    logic [15:0] cur_status = 16'h1234;
    logic [31:0] resume_addr = 32'h000B_EEF0;
    logic [31:0] next_pc = 32'h0000_8000;
    logic        exc_take;
    logic [3:0]  exc_vec;
    logic [31:0] save_addr;
    logic [15:0] save_status;
    logic        exc_busy;

    int checks = 0;
    int fails  = 0;

    logic [31:0] ret_log [64];
    int          rn = 0;
    logic [3:0]  tk_vec [32];
    logic [31:0] tk_ra  [32];
    int          tn = 0;

    precise_exc_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && ret_valid && rn < 64) begin
            ret_log[rn] = ret_addr;
            rn++;
        end
        if (rst_n && exc_take && tn < 32) begin
            tk_vec[tn] = exc_vec;
            tk_ra[tn]  = save_addr;
            tn++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dispatch(input logic [31:0] a, output logic [2:0] tag);
        disp_valid = 1'b1;
        disp_addr  = a;
        tag        = disp_tag;
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic finish(input logic [2:0] tag, input logic [3:0] c);
        fin_valid = 1'b1;
        fin_tag   = tag;
        fin_cause = c;
        @(negedge clk);
        fin_valid = 1'b0;
        fin_cause = '0;
    endtask

    task automatic hdone();
        handler_done = 1'b1;
        @(negedge clk);
        handler_done = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        chk(exc_busy == 1'b0, "R1 reset busy", 32'(exc_busy), 0);
        chk(disp_ready == 1'b1, "R1 reset ready", 32'(disp_ready), 1);
        chk(ret_valid == 1'b0 && exc_take == 1'b0, "R1 reset idle", 32'(ret_valid), 0);
    endtask

    task automatic t_order();
        logic [2:0] t0, t1, t2;
        int r0;
        r0 = rn;
        dispatch(32'h100, t0); dispatch(32'h104, t1); dispatch(32'h108, t2);
        finish(t2, 4'b0); finish(t1, 4'b0);
        idle(2);
        chk(rn == r0, "R1 no retire before oldest", 32'(rn - r0), 0);
        finish(t0, 4'b0);
        idle(5);
        chk(rn == r0 + 3, "R1 retire count", 32'(rn - r0), 3);
        chk(ret_log[r0] == 32'h100 && ret_log[r0+1] == 32'h104 && ret_log[r0+2] == 32'h108,
            "R1 retire order", ret_log[r0+1], 32'h104);
    endtask

    task automatic t_head_only();
        logic [2:0] t0, t1, t2, t3;
        int r0, k0;
        r0 = rn; k0 = tn;
        cur_status = 16'h5A5A;
        dispatch(32'h200, t0); dispatch(32'h204, t1); dispatch(32'h208, t2); dispatch(32'h20C, t3);
        finish(t2, 4'b0001); finish(t3, 4'b0);
        idle(3);
        chk(tn == k0, "R2 younger fault waits", 32'(tn - k0), 0);
        finish(t1, 4'b0); finish(t0, 4'b0);
        idle(5);
        chk(rn == r0 + 2, "R3 only older retired", 32'(rn - r0), 2);
        chk(tn == k0 + 1 && tk_vec[k0] == 4'd3, "R11 data vector", 32'(tk_vec[k0]), 3);
        chk(tk_ra[k0] == 32'h208, "R4 faulting address saved", tk_ra[k0], 32'h208);
        chk(save_status == 16'h5A5A, "R4 status saved", 32'(save_status), 32'h5A5A);
        chk(exc_busy == 1'b1, "R3 busy set", 32'(exc_busy), 1);
        hdone();
        idle(3);
        chk(rn == r0 + 2, "R3 younger flushed", 32'(rn - r0), 2);
        chk(exc_busy == 1'b0, "R5 busy cleared", 32'(exc_busy), 0);
    endtask

    task automatic t_older_first();
        logic [2:0] t0, t1;
        int r0, k0;
        r0 = rn; k0 = tn;
        dispatch(32'h300, t0); dispatch(32'h304, t1);
        finish(t1, 4'b0001);
        idle(2);
        finish(t0, 4'b0010);
        idle(5);
        chk(tn == k0 + 1 && tk_vec[k0] == 4'd4, "R2 older fault first", 32'(tk_vec[k0]), 4);
        chk(tk_ra[k0] == 32'h300, "R2 older address", tk_ra[k0], 32'h300);
        hdone();
        idle(3);
        chk(tn == k0 + 1 && rn == r0, "R3 younger fault discarded", 32'(tn - k0), 1);
    endtask

    task automatic t_multi();
        logic [2:0] t0;
        int r0, k0;
        r0 = rn; k0 = tn;
        dispatch(32'h400, t0);
        finish(t0, 4'b0011);
        idle(6);
        chk(tn == k0 + 1 && tk_vec[k0] == 4'd3, "R5 first cause only", 32'(tn - k0), 1);
        hdone();
        idle(2);
        chk(tn == k0 + 2 && tk_vec[k0+1] == 4'd4 && tk_ra[k0+1] == 32'h400,
            "R5 second cause", 32'(tk_vec[k0+1]), 4);
        hdone();
        idle(3);
        chk(rn == r0 && tn == k0 + 2, "R5 entry never retires", 32'(rn - r0), 0);
    endtask

    task automatic t_trap();
        logic [2:0] t0;
        int k0;
        k0 = tn;
        dispatch(32'h500, t0);
        finish(t0, 4'b0100);
        idle(3);
        chk(tk_vec[k0] == 4'd5 && tk_ra[k0] == 32'h000B_EEF0, "R6 trap resume", tk_ra[k0], 32'h000B_EEF0);
        hdone();
        dispatch(32'h504, t0);
        finish(t0, 4'b1000);
        idle(3);
        chk(tk_vec[k0+1] == 4'd6 && tk_ra[k0+1] == 32'h000B_EEF0, "R6 syscall resume", 32'(tk_vec[k0+1]), 6);
        hdone();
    endtask

    task automatic t_fp_mode();
        logic [2:0] t0;
        int k0;
        k0 = tn;
        fp_imprecise_en = 1'b1;
        dispatch(32'h600, t0);
        finish(t0, 4'b0010);
        idle(3);
        chk(tn == k0 + 1 && tk_vec[k0] == 4'd4 && tk_ra[k0] == 32'h600, "R9 fp still precise", tk_ra[k0], 32'h600);
        fp_imprecise_en = 1'b0;
        hdone();
    endtask

    task automatic t_async();
        logic [2:0] t0, t1;
        int r0, k0;
        r0 = rn; k0 = tn;
        dispatch(32'h700, t0); dispatch(32'h704, t1);
        async_req = 1'b1; @(negedge clk); async_req = 1'b0;
        idle(2);
        chk(disp_ready == 1'b0, "R7 dispatch stalled", 32'(disp_ready), 0);
        chk(tn == k0, "R7 waits for drain", 32'(tn - k0), 0);
        finish(t0, 4'b0); finish(t1, 4'b0);
        idle(5);
        chk(rn == r0 + 2, "R7 queue drained first", 32'(rn - r0), 2);
        chk(tn == k0 + 1 && tk_vec[k0] == 4'd8 && tk_ra[k0] == 32'h8000, "R7 async take", 32'(tk_vec[k0]), 8);
        hdone();
        chk(disp_ready == 1'b1, "R7 dispatch resumes", 32'(disp_ready), 1);
    endtask

    task automatic t_hard();
        logic [2:0] t0;
        dispatch(32'h800, t0);
        finish(t0, 4'b0001);
        idle(3);
        mchk_req = 1'b1; @(negedge clk); mchk_req = 1'b0;
        chk(exc_take && exc_vec == 4'd2 && save_addr == 32'h8000, "R8 machine check while busy", 32'(exc_vec), 2);
        sysrst_req = 1'b1; mchk_req = 1'b1; @(negedge clk); sysrst_req = 1'b0; mchk_req = 1'b0;
        chk(exc_take && exc_vec == 4'd1, "R8 reset over machine check", 32'(exc_vec), 1);
        hdone();
        dispatch(32'h900, t0);
        mchk_req = 1'b1; @(negedge clk); mchk_req = 1'b0;
        chk(save_addr == 32'h900, "R8 head address saved", save_addr, 32'h900);
        hdone();
    endtask

    task automatic t_full();
        logic [2:0] tg [6];
        int r0;
        r0 = rn;
        for (int i = 0; i < 6; i++) dispatch(32'hA00 + 32'(4*i), tg[i]);
        chk(disp_ready == 1'b0, "R10 full stalls dispatch", 32'(disp_ready), 0);
        finish(tg[3], 4'b0);
        for (int i = 0; i < 6; i++) finish(tg[i], 4'b0);
        idle(4);
        chk(rn == r0 + 6 && ret_log[r0+5] == 32'hA14, "R10 all six retire", 32'(rn - r0), 6);
        chk(disp_ready == 1'b1, "R10 ready after drain", 32'(disp_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_order();
        t_head_only();
        t_older_first();
        t_multi();
        t_trap();
        t_fp_mode();
        t_async();
        t_hard();
        t_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule